// File: doc/BRIEF.md
# Double-Buffered Converter Code Latch

This block sits between a parallel host bus and a 14-bit converter core. It holds the converter code in two register stages. A bus write, framed by an active-low select and an active-low write strobe, fills the first stage (the staging register). A separate active-low transfer strobe moves the staging register into the second stage (the code register), which drives the converter. Several of these blocks can share one transfer strobe, so a host can stage new codes in each channel and then update every output on the same clock edge.

All strobes are sampled in the system clock domain and are taken to be synchronous to it. An event completes on the cycle in which its strobe is first seen high again after being low. When the transfer strobe is held low without a break, each completed write fills both stages at once, so one bus cycle both loads and updates. When the transfer strobe is decoded from the address bus, the staging register and the code register occupy two addresses and two writes load and then update. If the transfer strobe is wired to the select line, both events complete in the same cycle. The block then resolves them in a fixed order: the old staging value moves to the code register first, and the new bus data then enters the staging register. A one-cycle pulse marks every transfer into the code register.

Top module: `dac_dbuf_latch`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `dac_code` is 0, the staging register is 0 and `dac_upd` is 0.
- R2: A write completes at the first rising clock edge at which `wr_n` is sampled 1, provided that `wr_n` and `cs_n` were both sampled 0 at the previous edge. The staging register then takes the `din` value sampled at that previous edge.
- R3: A rising `wr_n` that was not accompanied by `cs_n` low at the previous edge leaves the staging register unchanged.
- R4: A transfer completes at the first edge at which `ld_n` is sampled 1 after it was sampled 0. The code register then takes the staging value, and `dac_upd` is 1 for exactly the cycle in which the new code first appears on `dac_code`.
- R5: A completed write while `ld_n` was sampled 1 at the previous edge changes only the staging register. `dac_code` holds and `dac_upd` stays 0.
- R6: Tied-low mode: a completed write with `ld_n` sampled 0 at both the previous and the current edge loads the new data into both registers in the same cycle and raises `dac_upd`.
- R7: Collision: if a write and a transfer complete at the same edge, the code register takes the staging value from before the write, the staging register takes the new data, and `dac_upd` is raised.
- R8: `dac_code` changes only in a cycle in which `dac_upd` is 1. A repeated transfer with no write in between presents the same code again and still raises `dac_upd`.
- R9: The code width is set by the parameter `DATA_W`, which defaults to 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select that qualifies writes |
| wr_n | input | 1 | Active-low write strobe; the write completes on its rising edge |
| ld_n | input | 1 | Active-low transfer strobe; tie low for immediate update |
| din | input | DATA_W | Parallel code from the bus |
| dac_code | output | DATA_W | Code held in the second stage, driving the converter |
| dac_upd | output | 1 | One-cycle pulse on every transfer into the code register |

## Verification
The assertions assume that the strobes and data are already synchronous to `clk`. They also assume that the data for a write is stable on the last edge at which `wr_n` is seen low. The bench meets both assumptions by changing every input only on the falling clock edge. It holds `din` and `cs_n` for the whole strobe and lets each strobe stay low for at least one full cycle. The tied-low and collision cases are produced on purpose, by holding `ld_n` low across a write and by raising `ld_n` on the same edge as `wr_n`.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    // Kind of latch event resolved in one cycle
    typedef enum logic [2:0] {
        EV_IDLE      = 3'd0,
        EV_STAGE     = 3'd1,  // write fills staging only
        EV_XFER      = 3'd2,  // transfer staging -> code
        EV_IMMEDIATE = 3'd3,  // tied-low: write fills both
        EV_COLLIDE   = 3'd4   // transfer old, then stage new
    } latch_ev_e;

    localparam int unsigned DEFAULT_DATA_W = 14;

endpackage

// File: rtl/dac_strobe_detect.sv
module dac_strobe_detect #(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    output logic              wr_done,
    output logic              ld_rise,
    output logic              ld_steady_low,
    output logic              ld_prev_high,
    output logic [DATA_W-1:0] din_held
);

    typedef struct packed {
        logic              cs_n;
        logic              wr_n;
        logic              ld_n;
        logic [DATA_W-1:0] din;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cs_n = cs_n;
        smp_d.wr_n = wr_n;
        smp_d.ld_n = ld_n;
        smp_d.din  = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q.cs_n <= 1'b1;
            smp_q.wr_n <= 1'b1;
            smp_q.ld_n <= 1'b1;
            smp_q.din  <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    // Strobe qualification against the previous sample
    assign wr_done       = !smp_q.wr_n && wr_n && !smp_q.cs_n;
    assign ld_rise       = !smp_q.ld_n && ld_n;
    assign ld_steady_low = !smp_q.ld_n && !ld_n;
    assign ld_prev_high  = smp_q.ld_n;
    assign din_held      = smp_q.din;

endmodule

// File: rtl/dac_event_decode.sv
module dac_event_decode
    import dac_dbuf_pkg::*;
(
    input  logic      wr_done,
    input  logic      ld_rise,
    input  logic      ld_steady_low,
    input  logic      ld_prev_high,
    output latch_ev_e ev
);

    always_comb begin
        ev = EV_IDLE;
        if (wr_done && ld_rise) begin
            ev = EV_COLLIDE;
        end else if (wr_done && ld_steady_low) begin
            ev = EV_IMMEDIATE;
        end else if (wr_done && ld_prev_high) begin
            ev = EV_STAGE;
        end else if (ld_rise) begin
            ev = EV_XFER;
        end
    end

endmodule

// File: rtl/dac_latch_seq.sv
module dac_latch_seq
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  latch_ev_e         ev,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stage_code,
    output logic [DATA_W-1:0] out_code,
    output logic              upd
);

    typedef struct packed {
        logic [DATA_W-1:0] stage;
        logic [DATA_W-1:0] code;
        logic              upd;
    } lat_t;

    lat_t lat_d, lat_q;

    always_comb begin
        lat_d     = lat_q;
        lat_d.upd = 1'b0;
        unique case (ev)
            EV_STAGE: begin
                lat_d.stage = wdata;
            end
            EV_XFER: begin
                lat_d.code = lat_q.stage;
                lat_d.upd  = 1'b1;
            end
            EV_IMMEDIATE: begin
                lat_d.stage = wdata;
                lat_d.code  = wdata;
                lat_d.upd   = 1'b1;
            end
            EV_COLLIDE: begin
                lat_d.code  = lat_q.stage;
                lat_d.stage = wdata;
                lat_d.upd   = 1'b1;
            end
            default: begin
                lat_d.upd = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign stage_code = lat_q.stage;
    assign out_code   = lat_q.code;
    assign upd        = lat_q.upd;

endmodule

// File: rtl/dac_dbuf_latch.sv
module dac_dbuf_latch
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned DATA_W = DEFAULT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_upd
);

    logic              wr_done;
    logic              ld_rise;
    logic              ld_steady_low;
    logic              ld_prev_high;
    logic [DATA_W-1:0] din_held;
    logic [DATA_W-1:0] in_reg_q;
    latch_ev_e         ev;

    dac_strobe_detect #(.DATA_W(DATA_W)) u_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .wr_n          (wr_n),
        .ld_n          (ld_n),
        .din           (din),
        .wr_done       (wr_done),
        .ld_rise       (ld_rise),
        .ld_steady_low (ld_steady_low),
        .ld_prev_high  (ld_prev_high),
        .din_held      (din_held)
    );

    dac_event_decode u_decode (
        .wr_done       (wr_done),
        .ld_rise       (ld_rise),
        .ld_steady_low (ld_steady_low),
        .ld_prev_high  (ld_prev_high),
        .ev            (ev)
    );

    dac_latch_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .wdata      (din_held),
        .stage_code (in_reg_q),
        .out_code   (dac_code),
        .upd        (dac_upd)
    );

endmodule

// File: rtl/dac_dbuf_latch_chk.sv
module dac_dbuf_latch_chk #(
    parameter int unsigned DATA_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_n,
    input logic              ld_n,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] in_code,
    input logic [DATA_W-1:0] dac_code,
    input logic              dac_upd
);

    // Independent view of the previous port samples
    logic              cs_p, wr_p, ld_p;
    logic [DATA_W-1:0] din_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p  <= 1'b1;
            wr_p  <= 1'b1;
            ld_p  <= 1'b1;
            din_p <= '0;
        end else begin
            cs_p  <= cs_n;
            wr_p  <= wr_n;
            ld_p  <= ld_n;
            din_p <= din;
        end
    end

    logic wdone, ldone;
    assign wdone = !wr_p && wr_n && !cs_p;
    assign ldone = !ld_p && ld_n;

    a_r8_code_moves_only_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_upd |-> $stable(dac_code));

    a_r5_write_only_stages: assert property (@(posedge clk) disable iff (!rst_n)
        (wdone && ld_p) |=> (dac_code == $past(dac_code)) && !dac_upd && (in_code == $past(din_p)));

    a_r6_tied_low_updates_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wdone && !ld_p && !ld_n) |=> (dac_code == $past(din_p)) && (in_code == $past(din_p)) && dac_upd);

    a_r7_collision_order: assert property (@(posedge clk) disable iff (!rst_n)
        (wdone && ldone) |=> (dac_code == $past(in_code)) && (in_code == $past(din_p)) && dac_upd);

    a_r4_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (ldone && !wdone) |=> (dac_code == $past(in_code)) && dac_upd);

    a_r3_unselected_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdone && !ldone) |=> $stable(in_code) && !dac_upd);

endmodule

bind dac_dbuf_latch dac_dbuf_latch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .ld_n     (ld_n),
    .din      (din),
    .in_code  (in_reg_q),
    .dac_code (dac_code),
    .dac_upd  (dac_upd)
);

// File: tb/dac_dbuf_latch_tb.sv
module dac_dbuf_latch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          ld_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dac_code;
    logic          dac_upd;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dbuf_latch #(.DATA_W(DW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .ld_n     (ld_n),
        .din      (din),
        .dac_code (dac_code),
        .dac_upd  (dac_upd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus write; ld_n left as is. Ends on the negedge wr_n rises.
    task automatic bus_write(input logic [DW-1:0] d);
        @(negedge clk); din = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic pulse_ld();
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk); ld_n = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 code in reset", 32'(dac_code), 0);
        check("R1 pulse in reset", 32'(dac_upd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after reset", 32'(dac_code), 0);
        check("R1 pulse after reset", 32'(dac_upd), 0);
        pulse_ld();
        @(negedge clk);
        check("R1 staging zero after reset", 32'(dac_code), 0);
    endtask

    task automatic t_stage_then_xfer();
        bus_write(14'h1A5C);
        @(negedge clk);
        check("R5 code held on stage write", 32'(dac_code), 0);
        check("R5 no pulse on stage write", 32'(dac_upd), 0);
        pulse_ld();
        @(negedge clk);
        check("R2 R4 transferred code", 32'(dac_code), 32'h1A5C);
        check("R4 pulse on transfer", 32'(dac_upd), 1);
        @(negedge clk);
        check("R4 pulse one cycle", 32'(dac_upd), 0);
        check("R8 code holds", 32'(dac_code), 32'h1A5C);
    endtask

    task automatic t_width_edges();
        bus_write(14'h3FFF);
        pulse_ld();
        @(negedge clk);
        check("R9 full-scale code", 32'(dac_code), 32'h3FFF);
        bus_write(14'h0001);
        pulse_ld();
        @(negedge clk);
        check("R9 lsb code", 32'(dac_code), 32'h0001);
    endtask

    task automatic t_unselected();
        @(negedge clk); din = 14'h2222; cs_n = 1'b1; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        check("R3 no pulse unselected", 32'(dac_upd), 0);
        pulse_ld();
        @(negedge clk);
        check("R3 staging kept old value", 32'(dac_code), 32'h0001);
    endtask

    task automatic t_repeat_xfer();
        pulse_ld();
        @(negedge clk);
        check("R8 repeat transfer pulse", 32'(dac_upd), 1);
        check("R8 repeat transfer code", 32'(dac_code), 32'h0001);
    endtask

    task automatic t_tied_low();
        @(negedge clk); ld_n = 1'b0;
        @(negedge clk);
        bus_write(14'h0BEE);
        @(negedge clk);
        check("R6 immediate code", 32'(dac_code), 32'h0BEE);
        check("R6 immediate pulse", 32'(dac_upd), 1);
        bus_write(14'h1234);
        @(negedge clk);
        check("R6 second immediate code", 32'(dac_code), 32'h1234);
        @(negedge clk); ld_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_collision();
        bus_write(14'h0555);
        @(negedge clk); din = 14'h2AAA; cs_n = 1'b0; wr_n = 1'b0; ld_n = 1'b0;
        @(negedge clk); wr_n = 1'b1; cs_n = 1'b1; ld_n = 1'b1;
        @(negedge clk);
        check("R7 collision moves old staging", 32'(dac_code), 32'h0555);
        check("R7 collision pulse", 32'(dac_upd), 1);
        pulse_ld();
        @(negedge clk);
        check("R7 collision staged new data", 32'(dac_code), 32'h2AAA);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_stage_then_xfer();
        t_width_edges();
        t_unselected();
        t_repeat_xfer();
        t_tied_low();
        t_collision();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule